// File: doc/BRIEF.md
# Multi-format video sync generator

This block produces the horizontal and vertical timing for a digital camera video path. A horizontal pixel counter runs over one line period and a line counter runs over one frame. The line period follows from the sensor width and the TV system, and the frame is either 525 or 625 lines long. From these two counters the block derives:

- a horizontal drive pulse and a vertical drive pulse for the sensor timing,
- a field flag,
- a horizontal sync for the processing path,
- a composite sync.

All configuration arrives as static register values.

In free-running (master) mode the counters only follow their own period. In slave mode an external horizontal reset loads the horizontal counter with a programmed preset value. An external vertical reset clears the line counter and the field flag. Together these let the generator be re-phased to another video source.

Top module: `video_sync_gen`

## Requirements
- R1: `sensor_sel` picks the line period in clocks. The pairs below give 525-line / 625-line mode: code 0 gives 606/618, code 1 gives 806/824, code 2 gives 858/864, code 3 gives 910/908.
- R2: `mode_625` set to 0 gives 525-line frames and set to 1 gives 625-line frames. The line counter advances once per completed line and returns to line 0 after the last line.
- R3: The horizontal counter counts up by one per clock. When it holds a value at or above line period minus one, it returns to 0 on the next clock, and that clock ends the line.
- R4: With `slave_en`=1 and `hrst_in`=1, the horizontal counter loads `hpreset` on the next clock instead of counting. That clock does not end a line.
- R5: With `slave_en`=1 and `vrst_in`=1, the line counter and the field flag are both 0 after the next clock edge.
- R6: `field` is 0 on lines 0 to H-1 and 1 from line H to the end of the frame. H is 263 for 525-line frames and 313 for 625-line frames.
- R7: `hsync` is high while the horizontal counter is below 64. The internal horizontal drive is high while the counter is below 32.
- R8: The internal vertical drive is high on the first 9 lines of each field: lines 0 to 8 and lines H to H+8.
- R9: `hv_invert`=1 inverts `hdrive` and `vdrive`. It has no effect on `hsync`, `field` or `csync`.
- R10: `csync` equals, one clock later, the OR of the internal horizontal sync and the internal vertical drive.
- R11: With `slave_en`=0, `hrst_in` and `vrst_in` have no effect.
- R12: While `rst_n` is low, both counters, the field flag and `csync` are 0. So `hsync`=1 and `field`=0, and `hdrive` and `vdrive` equal the inverse of `hv_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor_sel | input | 2 | Sensor width code (R1) |
| mode_625 | input | 1 | 0 = 525 lines, 1 = 625 lines |
| slave_en | input | 1 | 1 = locked to external resets |
| hv_invert | input | 1 | Inverts hdrive and vdrive |
| hpreset | input | 10 | Horizontal counter load value |
| hrst_in | input | 1 | External horizontal reset |
| vrst_in | input | 1 | External vertical reset |
| hdrive | output | 1 | Horizontal drive pulse |
| vdrive | output | 1 | Vertical drive pulse |
| field | output | 1 | Field flag |
| hsync | output | 1 | Horizontal sync for processing |
| csync | output | 1 | Composite sync, one clock late |

## Verification
The hardest situations to reach are the frame wrap and the field boundaries. A free-running frame takes several hundred thousand clocks. To reach them quickly, the stimulus uses slave mode with the preset set to the line period minus one and pulses the horizontal reset every other clock. Each line then lasts two clocks, so the field change, the second-field vertical drive and the frame wrap arrive within about 1300 clocks.

Presets above the line period and switches of the sensor code in mid-line are also driven. These push the counter beyond its wrap point. Random phases then mix resets, modes and polarity against a cycle-accurate model in the bench.

// File: rtl/video_sync_gen.sv
module video_sync_gen #(
  parameter int CW         = 10,
  parameter int LW         = 10,
  parameter int HSYNC_CLKS = 64,
  parameter int HDRV_CLKS  = 32,
  parameter int VDRV_LINES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sensor_sel,
  input  logic          mode_625,
  input  logic          slave_en,
  input  logic          hv_invert,
  input  logic [CW-1:0] hpreset,
  input  logic          hrst_in,
  input  logic          vrst_in,
  output logic          hdrive,
  output logic          vdrive,
  output logic          field,
  output logic          hsync,
  output logic          csync
);

  // R1: line period table, indexed by sensor code and line mode
  function automatic logic [CW-1:0] line_period(input logic [1:0] s, input logic l625);
    case (s)
      2'd0:    line_period = l625 ? CW'(618) : CW'(606);
      2'd1:    line_period = l625 ? CW'(824) : CW'(806);
      2'd2:    line_period = l625 ? CW'(864) : CW'(858);
      default: line_period = l625 ? CW'(908) : CW'(910);
    endcase
  endfunction

  logic [CW-1:0] hcnt;
  logic [LW-1:0] vcnt;
  logic          fld;
  logic          csync_q;

  wire [CW-1:0] lp      = line_period(sensor_sel, mode_625);
  wire [LW-1:0] nlines  = mode_625 ? LW'(625) : LW'(525);
  wire [LW-1:0] half    = mode_625 ? LW'(313) : LW'(263);
  wire          hload   = slave_en & hrst_in;
  wire          vload   = slave_en & vrst_in;
  wire          line_end = !hload && (hcnt >= lp - CW'(1));
  wire          last_line = vcnt >= nlines - LW'(1);

  // R3, R4: horizontal counter
  always_ff @(posedge clk) begin
    if (!rst_n)        hcnt <= '0;
    else if (hload)    hcnt <= hpreset;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + CW'(1);
  end

  // R2, R5, R6: line counter and field flag
  always_ff @(posedge clk) begin
    if (!rst_n || vload) begin
      vcnt <= '0;
      fld  <= 1'b0;
    end else if (line_end) begin
      if (last_line) begin
        vcnt <= '0;
        fld  <= 1'b0;
      end else begin
        vcnt <= vcnt + LW'(1);
        if (vcnt + LW'(1) == half) fld <= 1'b1;
      end
    end
  end

  // R7, R8: internal pulses
  wire hs_int = hcnt < CW'(HSYNC_CLKS);
  wire hd_int = hcnt < CW'(HDRV_CLKS);
  wire vd_int = (vcnt < LW'(VDRV_LINES)) ||
                ((vcnt >= half) && (vcnt < half + LW'(VDRV_LINES)));

  // R10: composite sync, one clock behind
  always_ff @(posedge clk) begin
    if (!rst_n) csync_q <= 1'b0;
    else        csync_q <= hs_int | vd_int;
  end

  // R9: drive polarity
  assign hdrive = hd_int ^ hv_invert;
  assign vdrive = vd_int ^ hv_invert;
  assign hsync  = hs_int;
  assign field  = fld;
  assign csync  = csync_q;

endmodule

module video_sync_gen_chk #(
  parameter int CW = 10,
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_en,
  input logic          hv_invert,
  input logic          hrst_in,
  input logic          vrst_in,
  input logic [CW-1:0] hpreset,
  input logic          hsync,
  input logic          vdrive,
  input logic          field,
  input logic          csync,
  input logic [CW-1:0] hcnt,
  input logic [LW-1:0] vcnt
);

  a_r4_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && hrst_in) |=> (hcnt == $past(hpreset)));

  a_r5_vrst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && vrst_in) |=> (vcnt == '0 && !field));

  a_r11_master_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && hcnt < CW'(100)) |=> (hcnt == $past(hcnt) + CW'(1)));

  a_r6_field_low_line0: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt == '0) |-> !field);

  a_r10_csync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (csync == $past(hsync || (vdrive ^ hv_invert))));

endmodule

bind video_sync_gen video_sync_gen_chk #(.CW(CW), .LW(LW)) u_chk (.*);

// File: tb/test_video_sync_gen.sv
`timescale 1ns/1ps
module test_video_sync_gen;
  logic clk = 0, rst_n = 0;
  logic [1:0] sensor_sel = 0;
  logic mode_625 = 0, slave_en = 0, hv_invert = 0, hrst_in = 0, vrst_in = 0;
  logic [9:0] hpreset = 0;
  logic hdrive, vdrive, field, hsync, csync;

  video_sync_gen i_video_sync_gen (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int mh = 0, mv = 0, mf = 0, mcs = 0;

  function automatic int exp_lp(input int s, input int l625);
    int t5 [4] = '{606, 806, 858, 910};
    int t6 [4] = '{618, 824, 864, 908};
    return l625 ? t6[s] : t5[s];
  endfunction
  function automatic int exp_half(input int l625);
    return l625 ? 313 : 263;
  endfunction
  function automatic int exp_vd(input int v, input int l625);
    int h = exp_half(l625);
    return ((v < 9) || (v >= h && v < h + 9)) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, expv, mh, mv);
    end
  endtask

  task automatic compare();
    chk("R7 hsync", hsync, mh < 64);
    chk("R9 hdrive", hdrive, (mh < 32) ^ hv_invert);
    chk("R8 vdrive", vdrive, exp_vd(mv, mode_625) ^ hv_invert);
    chk("R6 field", field, mf);
    chk("R10 csync", csync, mcs);
  endtask

  // one clock: inputs are already set; model follows R1-R5, R10, R11
  task automatic step();
    int lp, hl, vl, le, n;
    @(posedge clk);
    if (!rst_n) begin
      mh = 0; mv = 0; mf = 0; mcs = 0;
    end else begin
      lp = exp_lp(sensor_sel, mode_625);
      n  = mode_625 ? 625 : 525;
      hl = slave_en && hrst_in;
      vl = slave_en && vrst_in;
      le = !hl && (mh >= lp - 1);
      mcs = (mh < 64) || exp_vd(mv, mode_625);
      if (hl) mh = hpreset; else if (le) mh = 0; else mh = mh + 1;
      if (vl) begin mv = 0; mf = 0; end
      else if (le) begin
        if (mv >= n - 1) begin mv = 0; mf = 0; end
        else begin mv = mv + 1; if (mv == exp_half(mode_625)) mf = 1; end
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic fast_frame(input int s, input int l625);
    sensor_sel = 2'(s); mode_625 = l625[0]; slave_en = 1; vrst_in = 0;
    hpreset = 10'(exp_lp(s, l625) - 1);
    for (int i = 0; i < 2 * (l625 ? 625 : 525) + 40; i++) begin
      hrst_in = (i % 2) == 0;  // R4: two-clock lines, R2 wrap, R6 field
      step();
    end
    hrst_in = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R12: reset state, both polarities
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      hv_invert = p[0];
      step();
      chk("R12 hsync", hsync, 1);
      chk("R12 field", field, 0);
      chk("R12 csync", csync, 0);
      chk("R12 hdrive", hdrive, 1 ^ p);
      chk("R12 vdrive", vdrive, 1 ^ p);
    end
    hv_invert = 0;
    rst_n = 1;
    // R11: master mode ignores external resets
    for (int i = 0; i < 1300; i++) begin
      hrst_in = $urandom_range(0, 3) == 0; vrst_in = $urandom_range(0, 7) == 0;
      hpreset = 10'($urandom_range(0, 1023));
      step();
    end
    hrst_in = 0; vrst_in = 0;
    // R1, R3: every sensor code and line mode, two lines each
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 2; m++) begin
        sensor_sel = 2'(s); mode_625 = m[0]; hv_invert = (s + m) % 2 == 1;
        for (int i = 0; i < 2 * exp_lp(s, m) + 5; i++) step();
      end
    // R2, R6, R8: frame wrap and field edges via fast lines
    fast_frame(0, 0);
    fast_frame(3, 1);
    // R5: vertical reset in slave mode mid-frame
    vrst_in = 1; step(); vrst_in = 0;
    chk("R5 field after vrst", field, 0);
    // R3: preset above the line period wraps next clock
    hpreset = 10'd1023; hrst_in = 1; step(); hrst_in = 0;
    for (int i = 0; i < 80; i++) step();
    // random mix
    for (int blk = 0; blk < 12; blk++) begin
      sensor_sel = 2'($urandom_range(0, 3)); mode_625 = 1'($urandom_range(0, 1));
      slave_en = 1'($urandom_range(0, 1)); hv_invert = 1'($urandom_range(0, 1));
      hpreset = 10'($urandom_range(0, 1023));
      for (int i = 0; i < 2500; i++) begin
        hrst_in = $urandom_range(0, 400) == 0;
        vrst_in = $urandom_range(0, 1500) == 0;
        step();
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule